// File: doc/BRIEF.md
# Recovery-Loop Lock Controller

This block is the digital supervisor of a clock-and-data-recovery loop. It runs on one fast system clock. It receives single-cycle strobes, already brought into that clock domain, for each edge of the 622.08 MHz reference clock and for each edge of the recovered clock divided by 16. A frequency meter counts divided-clock strobes over a fixed number of reference strobes. An activity monitor samples the incoming serial bit on every divided-clock strobe and flags data that has stopped changing. The external data-valid input is expected to be pulled low by the optics side on loss of signal or bad data.

A two-state controller selects the loop. In the reference state the analog loop synthesises from the reference clock. In the tracking state it follows the data phase. Tracking is entered only after consecutive good measurement windows with valid, changing data. Any failed condition sends the loop back to the reference. The lock output is high only while tracking with all conditions met. A bypass input switches the acquisition aid off: the controller is pinned to tracking, and lock then depends only on data-valid and data activity.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While reset is applied, and for two clock edges after its release, track_mode_o (1 = data tracking, 0 = reference loop) and lock_o are both 0.
- R2: A measurement window closes on every WIN_LEN-th reference strobe. The divided-clock strobes seen in that window, counting one that coincides with the closing strobe, pass if they differ from WIN_LEN by at most FREQ_TOL, and fail at FREQ_TOL+1 in either direction.
- R3: From the reference state, with bypass low, the controller enters tracking and raises lock only at the end of the ENTER_WINS-th consecutive passing window during which data-valid stayed high and data was never flagged stuck. Any cycle with data-valid low or data stuck restarts the count.
- R4: In tracking with bypass low, a failing window returns the controller to the reference state and drops lock on the second edge after the closing strobe.
- R5: With data-valid low, lock_o is 0 from the next edge on. With bypass also low, track_mode_o is 0 from the next edge on.
- R6: Data is flagged stuck once STUCK_LEN consecutive divided-clock strobes sample the same bit as the strobe before. While stuck, lock drops and, with bypass low, the reference state is selected. The flag clears at the first sampled change.
- R7: While aid_bypass_i is high, track_mode_o is 1 from the next edge on, whatever the frequency result, and lock_o equals data-valid and not stuck.
- R8: lock_o is never 1 while track_mode_o is 0.
- R9: When bypass is released, the controller stays in tracking until a condition of R4, R5 or R6 fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick_i | input | 1 | One-cycle strobe per reference-clock edge |
| rec_tick_i | input | 1 | One-cycle strobe per divided recovered-clock edge |
| rx_bit_i | input | 1 | Serial data bit, sampled on rec_tick_i |
| data_valid_i | input | 1 | External data-valid, active high |
| aid_bypass_i | input | 1 | Acquisition-aid disable, active high |
| track_mode_o | output | 1 | Loop select: 1 data phase tracking, 0 reference loop |
| lock_o | output | 1 | Lock detect, active high |

## Verification
Data-valid and bypass act on the outputs at the first edge after they change. The stuck flag is registered, so it reaches the outputs one edge after the strobe that completes the run. A window result is registered at the closing reference strobe and acts on the controller one edge later, and the reset synchroniser adds two edges after release. The bench's behavioural model advances at each rising edge on the inputs driven at the previous falling edge, and its outputs are compared with the design's at every falling edge. The named spot checks are timed with margins of whole windows, so they do not depend on where a window boundary falls.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
  typedef enum logic {
    LOOP_REF  = 1'b0,
    LOOP_DATA = 1'b1
  } loop_sel_e;
endpackage

// File: rtl/cdr_rst_sync.sv
module cdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
  parameter int WIN_LEN  = 65536,
  parameter int FREQ_TOL = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic rec_tick_i,
  output logic win_done_o,
  output logic win_pass_o
);
  localparam int          RW    = $clog2(WIN_LEN);
  localparam int          CW    = $clog2(WIN_LEN + FREQ_TOL + 2) + 1;
  localparam logic [RW-1:0] LAST = RW'(WIN_LEN - 1);
  localparam logic [CW:0] LO    = (CW+1)'(WIN_LEN - FREQ_TOL);
  localparam logic [CW:0] HI    = (CW+1)'(WIN_LEN + FREQ_TOL);
  localparam logic [CW:0] CMAX  = {1'b0, {CW{1'b1}}};

  logic [RW-1:0] ref_q, ref_d;
  logic [CW-1:0] rec_q, rec_d;
  logic          done_q, done_d;
  logic          pass_q, pass_d;
  logic [CW:0]   rec_sum;
  logic [CW-1:0] rec_sat;

  always_comb begin
    rec_sum = {1'b0, rec_q} + {{CW{1'b0}}, rec_tick_i};
    rec_sat = (rec_sum > CMAX) ? CMAX[CW-1:0] : rec_sum[CW-1:0];
    ref_d   = ref_q;
    rec_d   = rec_sat;
    done_d  = 1'b0;
    pass_d  = pass_q;
    if (ref_tick_i) begin
      if (ref_q == LAST) begin
        ref_d  = '0;
        rec_d  = '0;
        done_d = 1'b1;
        pass_d = (rec_sum >= LO) && (rec_sum <= HI);
      end else begin
        ref_d  = ref_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      rec_q  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      rec_q  <= rec_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign win_done_o = done_q;
  assign win_pass_o = pass_q;
endmodule

// File: rtl/cdr_activity_mon.sv
module cdr_activity_mon #(
  parameter int STUCK_LEN = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rec_tick_i,
  input  logic rx_bit_i,
  output logic stuck_o
);
  localparam int            RUNW  = $clog2(STUCK_LEN + 1);
  localparam logic [RUNW-1:0] LIMIT = RUNW'(STUCK_LEN);

  logic            last_q, last_d;
  logic [RUNW-1:0] run_q, run_d;
  logic            stuck;

  assign stuck = (run_q == LIMIT);

  always_comb begin
    last_d = last_q;
    run_d  = run_q;
    if (rec_tick_i) begin
      last_d = rx_bit_i;
      if (rx_bit_i != last_q) run_d = '0;
      else if (!stuck)        run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      run_q  <= '0;
    end else begin
      last_q <= last_d;
      run_q  <= run_d;
    end
  end

  assign stuck_o = stuck;
endmodule

// File: rtl/cdr_lock_fsm.sv
module cdr_lock_fsm
  import cdr_lock_pkg::*;
#(
  parameter int ENTER_WINS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_done_i,
  input  logic win_pass_i,
  input  logic data_valid_i,
  input  logic stuck_i,
  input  logic bypass_i,
  output logic track_o,
  output logic lock_o
);
  localparam int          SW    = $clog2(ENTER_WINS + 1);
  localparam logic [SW-1:0] SLAST = SW'(ENTER_WINS - 1);

  loop_sel_e     state_q, state_d;
  logic [SW-1:0] streak_q, streak_d;
  logic          lock_q, lock_d;
  logic          data_ok;

  assign data_ok = data_valid_i && !stuck_i;

  always_comb begin
    state_d  = state_q;
    streak_d = streak_q;
    if (bypass_i) begin
      state_d  = LOOP_DATA;
      streak_d = '0;
    end else begin
      case (state_q)
        LOOP_REF: begin
          if (!data_ok) begin
            streak_d = '0;
          end else if (win_done_i) begin
            if (!win_pass_i) begin
              streak_d = '0;
            end else if (streak_q == SLAST) begin
              streak_d = '0;
              state_d  = LOOP_DATA;
            end else begin
              streak_d = streak_q + 1'b1;
            end
          end
        end
        default: begin
          if (!data_ok || (win_done_i && !win_pass_i)) begin
            state_d  = LOOP_REF;
            streak_d = '0;
          end
        end
      endcase
    end
    lock_d = (state_d == LOOP_DATA) && data_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= LOOP_REF;
      streak_q <= '0;
      lock_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      streak_q <= streak_d;
      lock_q   <= lock_d;
    end
  end

  assign track_o = (state_q == LOOP_DATA);
  assign lock_o  = lock_q;
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
  parameter int WIN_LEN    = 65536,
  parameter int FREQ_TOL   = 32,
  parameter int STUCK_LEN  = 256,
  parameter int ENTER_WINS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic rec_tick_i,
  input  logic rx_bit_i,
  input  logic data_valid_i,
  input  logic aid_bypass_i,
  output logic track_mode_o,
  output logic lock_o
);
  logic rst_n_int;
  logic win_done;
  logic win_pass;
  logic data_stuck;

  cdr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  cdr_freq_meter #(.WIN_LEN(WIN_LEN), .FREQ_TOL(FREQ_TOL)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .ref_tick_i (ref_tick_i),
    .rec_tick_i (rec_tick_i),
    .win_done_o (win_done),
    .win_pass_o (win_pass)
  );

  cdr_activity_mon #(.STUCK_LEN(STUCK_LEN)) u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .rec_tick_i (rec_tick_i),
    .rx_bit_i   (rx_bit_i),
    .stuck_o    (data_stuck)
  );

  cdr_lock_fsm #(.ENTER_WINS(ENTER_WINS)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .win_done_i   (win_done),
    .win_pass_i   (win_pass),
    .data_valid_i (data_valid_i),
    .stuck_i      (data_stuck),
    .bypass_i     (aid_bypass_i),
    .track_o      (track_mode_o),
    .lock_o       (lock_o)
  );
endmodule

// File: rtl/cdr_lock_ctrl_chk.sv
module cdr_lock_ctrl_chk (
  input logic clk_i,
  input logic rst_n,
  input logic data_valid_i,
  input logic aid_bypass_i,
  input logic track_mode_o,
  input logic lock_o,
  input logic win_done,
  input logic win_pass,
  input logic stuck
);
  a_r8_lock_in_track: assert property (@(posedge clk_i) disable iff (!rst_n)
    lock_o |-> track_mode_o);

  a_r5_invalid_no_lock: assert property (@(posedge clk_i) disable iff (!rst_n)
    !data_valid_i |=> !lock_o);

  a_r5_invalid_to_ref: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!data_valid_i && !aid_bypass_i) |=> !track_mode_o);

  a_r7_bypass_tracks: assert property (@(posedge clk_i) disable iff (!rst_n)
    aid_bypass_i |=> track_mode_o);

  a_r6_stuck_no_lock: assert property (@(posedge clk_i) disable iff (!rst_n)
    stuck |=> !lock_o);

  a_r3_entry_at_window: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(track_mode_o) && !$past(aid_bypass_i)) |-> $past(win_done));

  a_r4_fail_exits: assert property (@(posedge clk_i) disable iff (!rst_n)
    (win_done && !win_pass && !aid_bypass_i) |=> !track_mode_o);

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    win_done |=> !win_done);
endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n_int),
  .data_valid_i (data_valid_i),
  .aid_bypass_i (aid_bypass_i),
  .track_mode_o (track_mode_o),
  .lock_o       (lock_o),
  .win_done     (win_done),
  .win_pass     (win_pass),
  .stuck        (data_stuck)
);

// File: tb/cdr_lock_ctrl_test.sv
`timescale 1ns/1ps
module cdr_lock_ctrl_test;
  localparam int W  = 64;
  localparam int T  = 2;
  localparam int S  = 8;
  localparam int E  = 2;
  localparam int WC = W * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, rec_tick = 1'b0, rx_bit = 1'b0;
  logic dvalid = 1'b0, bypass = 1'b0;
  logic track, lock;

  always #2 clk = ~clk;

  cdr_lock_ctrl #(.WIN_LEN(W), .FREQ_TOL(T), .STUCK_LEN(S), .ENTER_WINS(E)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .rec_tick_i(rec_tick),
    .rx_bit_i(rx_bit), .data_valid_i(dvalid), .aid_bypass_i(bypass),
    .track_mode_o(track), .lock_o(lock));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit cmp_on = 0, gen_on = 0, toggle_en = 0;
  int extra = 0;

  // behavioural reference model
  bit m_s0 = 0, m_s1 = 0;
  int m_refs = 0, m_recs = 0, m_same = 0, m_streak = 0;
  bit m_done = 0, m_pass = 0, m_last = 0, m_track = 0, m_lock = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0;
      m_refs = 0; m_recs = 0; m_same = 0; m_streak = 0;
      m_done = 0; m_pass = 0; m_last = 0; m_track = 0; m_lock = 0;
    end else begin
      if (m_s1) begin
        bit ok, was_done, was_pass;
        ok = dvalid && (m_same < S);
        was_done = m_done; was_pass = m_pass;
        if (bypass) begin
          m_track = 1; m_streak = 0;
        end else if (!m_track) begin
          if (!ok) m_streak = 0;
          else if (was_done) begin
            if (!was_pass) m_streak = 0;
            else begin
              m_streak++;
              if (m_streak >= E) begin m_track = 1; m_streak = 0; end
            end
          end
        end else if (!ok || (was_done && !was_pass)) begin
          m_track = 0; m_streak = 0;
        end
        m_lock = m_track && ok;
        m_done = 0;
        if (ref_tick) begin
          m_refs++;
          if (m_refs == W) begin
            int tot;
            tot = m_recs + int'(rec_tick);
            m_pass = (tot >= W - T) && (tot <= W + T);
            m_done = 1; m_refs = 0; m_recs = 0;
          end else m_recs += int'(rec_tick);
        end else m_recs += int'(rec_tick);
        if (rec_tick) begin
          if (rx_bit != m_last) m_same = 0;
          else if (m_same < S) m_same++;
          m_last = rx_bit;
        end
      end
      m_s1 = m_s0; m_s0 = 1;
    end
  end

  // per-cycle comparison and strobe generation
  initial begin
    int ph, wcnt, budget;
    ph = 0; wcnt = 0; budget = 0;
    forever begin
      @(negedge clk);
      if (cmp_on) begin
        n_cmp++;
        if (track !== m_track || lock !== m_lock) begin
          n_bad++;
          $display("FAIL %s cycle compare: track=%b lock=%b expected track=%b lock=%b",
                   cur_req, track, lock, m_track, m_lock);
        end
      end
      ref_tick = 0; rec_tick = 0;
      if (gen_on) begin
        ph = (ph + 1) % 4;
        if (ph == 0) begin
          ref_tick = 1;
          if (wcnt == 0) budget = extra;
          wcnt = (wcnt + 1) % W;
          if (budget < 0) budget++;
          else rec_tick = 1;
        end else if (ph == 2 && budget > 0) begin
          rec_tick = 1; budget--;
        end
        if (ph == 1 && toggle_en) rx_bit = ~rx_bit;
      end
    end
  end

  task automatic expect_out(string req, logic et, logic el);
    n_cmp++;
    if (track !== et || lock !== el) begin
      n_bad++;
      $display("FAIL %s: track=%b lock=%b expected track=%b lock=%b", req, track, lock, et, el);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    cmp_on = 1;
    expect_out("R1 in reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1 after release", 0, 0);
    dvalid = 1; toggle_en = 1; bypass = 1;
    @(negedge clk);
    expect_out("R1 sync hold", 0, 0);
    bypass = 0;
    wait_cyc(4);
    gen_on = 1;

    cur_req = "R3";
    wait_cyc(WC + 40);
    expect_out("R3 one window", 0, 0);
    wait_cyc(WC);
    expect_out("R3 two windows", 1, 1);

    cur_req = "R2";
    extra = T;       wait_cyc(3 * WC);
    expect_out("R2 plus tol passes", 1, 1);
    extra = T + 1;   wait_cyc(2 * WC + 20);
    expect_out("R2 R4 plus tol+1 fails", 0, 0);
    extra = -T;      wait_cyc(4 * WC);
    expect_out("R2 minus tol passes", 1, 1);
    extra = -T - 1;  wait_cyc(2 * WC + 20);
    expect_out("R2 R4 minus tol+1 fails", 0, 0);
    extra = 0;       wait_cyc(4 * WC);
    expect_out("R3 relock", 1, 1);

    cur_req = "R5";
    dvalid = 0; wait_cyc(2);
    expect_out("R5 valid low", 0, 0);
    wait_cyc(100);
    expect_out("R5 valid held low", 0, 0);
    dvalid = 1; wait_cyc(100);
    expect_out("R3 streak restarts", 0, 0);
    wait_cyc(4 * WC);
    expect_out("R3 relock after valid", 1, 1);

    cur_req = "R6";
    toggle_en = 0; wait_cyc(20);
    expect_out("R6 short run", 1, 1);
    wait_cyc(40);
    expect_out("R6 stuck data", 0, 0);
    toggle_en = 1; wait_cyc(4 * WC);
    expect_out("R6 R3 recovery", 1, 1);

    cur_req = "R7";
    extra = -20; bypass = 1; wait_cyc(3);
    expect_out("R7 bypass on", 1, 1);
    wait_cyc(2 * WC + 40);
    expect_out("R7 bad freq ignored", 1, 1);
    dvalid = 0; wait_cyc(3);
    expect_out("R7 R8 valid low", 1, 0);
    dvalid = 1; wait_cyc(3);
    expect_out("R7 valid back", 1, 1);
    toggle_en = 0; wait_cyc(60);
    expect_out("R7 stuck", 1, 0);
    toggle_en = 1; wait_cyc(20);
    expect_out("R7 activity back", 1, 1);

    cur_req = "R9";
    bypass = 0; wait_cyc(3);
    expect_out("R9 stays tracking", 1, 1);
    wait_cyc(WC + 20);
    expect_out("R9 R4 failing window", 0, 0);
    extra = 0; wait_cyc(4 * WC);
    expect_out("R3 final lock", 1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule